// File: doc/BRIEF.md
# Multi-Lane PHY Status and Control Register Bank

This block is the software-visible register file of a multi-lane serial PHY. A management agent reaches it through a word-addressed port with separate read and write strobes. The bank answers a window of addresses starting at word 0x300. It returns identification constants and a scratch word. It exposes live per-lane lock status, and it drives a per-lane serial loopback enable out to the lanes. The PHY datapath, transceivers and clock logic are outside the block, and their status arrives on plain input ports.

Two features go beyond plain storage. The first is an indirect flag window. A 3-bit select register picks one of eight per-lane FIFO flag types, and a companion data register then shows that type with one bit per lane. The second is a sticky frame-error bit with a clear register that the agent writes and must later write back to zero. While the clear register holds 1, the frame-error bit and the sticky deskew-error bit are forced low and cannot be set. Loss of word lock on any lane also forces the frame-error bit low.

Reads go through a two-state response machine. RD_IDLE waits for a request. The transition RD_IDLE to RD_RESP is taken on a read strobe and captures the addressed word. RD_RESP presents that word with a one-cycle valid pulse. It stays in RD_RESP on a back-to-back read and returns to RD_IDLE when no read is pending.

Top module: `phy_csr_bank`

## Requirements
- R1: A synchronous active-high reset clears the scratch, loopback, flag-select and clear registers, both sticky bits, and the read response (read-valid low).
- R2: Reads of 0x300 return the REV_ID parameter. Reads of 0x302, 0x303 and 0x304 return 0x00003235, 0x00004745 and 0x00706373. Writes to these addresses leave them unchanged.
- R3: Address 0x301 is a 32-bit scratch register that reads back the last value written to it.
- R4: Address 0x313 holds one loopback enable per lane, bit n for lane n, driven on loopback_o. Bits above the lane count read zero.
- R5: Reads of 0x312 return word_lock_i. Reads of 0x321 return cdr_lock_i. Reads of 0x326 return pcs_aligned_i in bit 0. All of them are live values and have zero upper bits.
- R6: Address 0x314 holds a 3-bit flag-type code in bits 2:0. A read of 0x315 returns, in bit n, fifo_flags_i[code*LANES + n].
- R7: Bit 0 of 0x323 is set by a one-cycle frame_err_i pulse when all lanes hold word lock and the clear register is 0. It then stays set.
- R8: Address 0x324 bit 0 is a read/write clear register. While it is 1, bit 0 of 0x323 and bit 1 of 0x329 read 0 and cannot be set. After 0 is written, new errors are recorded again.
- R9: While any lane's word_lock_i is low, bit 0 of 0x323 is cleared and stays cleared.
- R10: Address 0x329 returns deskew_done_i live in bit 0. Bit 1 is a sticky bit set by a deskew_err_i pulse, and only the clear register clears it.
- R11: A read strobe gives csr_rvalid high with the addressed word on csr_rdata exactly one cycle later. The valid stays high for exactly one cycle per strobe. Unmapped addresses read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | ADDR_W | Word address |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rd | input | 1 | Read strobe |
| csr_rdata | output | 32 | Registered read data |
| csr_rvalid | output | 1 | Read data valid pulse |
| word_lock_i | input | LANES | Per-lane block-boundary lock |
| cdr_lock_i | input | LANES | Per-lane receive CDR lock |
| fifo_flags_i | input | 8*LANES | Eight FIFO flag types, each LANES bits wide |
| frame_err_i | input | 1 | Frame error event pulse |
| pcs_aligned_i | input | 1 | Receive PCS fully aligned |
| deskew_done_i | input | 1 | Lanes deskewed |
| deskew_err_i | input | 1 | Deskew error event pulse |
| loopback_o | output | LANES | Per-lane serial loopback enable |

## Verification
The hardest situation to reach is the interplay of the level-held clear with the error inputs. A frame error has to arrive while the clear register is 1, and again after software writes it back to 0. A frame error also has to arrive while only one lane has lost word lock. The bench gets there by writing the clear register and driving lock patterns directly. It pulses frame_err_i and deskew_err_i between the writes and reads back 0x323 and 0x329 after each step. The flag window and the lock inputs are swept over every select code and every lane pattern, and the expected values are computed by shifting the stimulus.

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;

    localparam int unsigned A_REV      = 32'h300;
    localparam int unsigned A_SCRATCH  = 32'h301;
    localparam int unsigned A_NAME0    = 32'h302;
    localparam int unsigned A_NAME1    = 32'h303;
    localparam int unsigned A_NAME2    = 32'h304;
    localparam int unsigned A_WLOCK    = 32'h312;
    localparam int unsigned A_LOOP     = 32'h313;
    localparam int unsigned A_FSEL     = 32'h314;
    localparam int unsigned A_FDATA    = 32'h315;
    localparam int unsigned A_CDR      = 32'h321;
    localparam int unsigned A_FRMERR   = 32'h323;
    localparam int unsigned A_CLR      = 32'h324;
    localparam int unsigned A_ALIGNED  = 32'h326;
    localparam int unsigned A_DESKEW   = 32'h329;

    localparam logic [31:0] NAME0_VAL = 32'h0000_3235;
    localparam logic [31:0] NAME1_VAL = 32'h0000_4745;
    localparam logic [31:0] NAME2_VAL = 32'h0070_6373;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_REV,
        SEL_SCRATCH,
        SEL_NAME0,
        SEL_NAME1,
        SEL_NAME2,
        SEL_WLOCK,
        SEL_LOOP,
        SEL_FSEL,
        SEL_FDATA,
        SEL_CDR,
        SEL_FRMERR,
        SEL_CLR,
        SEL_ALIGNED,
        SEL_DESKEW
    } reg_sel_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

endpackage

// File: rtl/phy_csr_decode.sv
module phy_csr_decode
    import phy_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        case (32'(addr))
            A_REV:     sel = SEL_REV;
            A_SCRATCH: sel = SEL_SCRATCH;
            A_NAME0:   sel = SEL_NAME0;
            A_NAME1:   sel = SEL_NAME1;
            A_NAME2:   sel = SEL_NAME2;
            A_WLOCK:   sel = SEL_WLOCK;
            A_LOOP:    sel = SEL_LOOP;
            A_FSEL:    sel = SEL_FSEL;
            A_FDATA:   sel = SEL_FDATA;
            A_CDR:     sel = SEL_CDR;
            A_FRMERR:  sel = SEL_FRMERR;
            A_CLR:     sel = SEL_CLR;
            A_ALIGNED: sel = SEL_ALIGNED;
            A_DESKEW:  sel = SEL_DESKEW;
            default:   sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/phy_csr_sticky.sv
module phy_csr_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic hold_clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || hold_clr_i) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/phy_csr_flag_mux.sv
module phy_csr_flag_mux #(
    parameter int LANES  = 4,
    parameter int FSEL_W = 3,
    localparam int NTYPES = 1 << FSEL_W
) (
    input  logic [NTYPES*LANES-1:0] flags_i,
    input  logic [FSEL_W-1:0]       sel_i,
    output logic [LANES-1:0]        lanes_o
);
    logic [LANES-1:0] by_type [NTYPES];

    for (genvar t = 0; t < NTYPES; t++) begin : g_type
        assign by_type[t] = flags_i[t*LANES +: LANES];
    end

    assign lanes_o = by_type[sel_i];
endmodule

// File: rtl/phy_csr_bank.sv
module phy_csr_bank
    import phy_csr_pkg::*;
#(
    parameter int          LANES  = 4,
    parameter int          ADDR_W = 12,
    parameter int          FSEL_W = 3,
    parameter logic [31:0] REV_ID = 32'h0001_0200,
    localparam int         NTYPES = 1 << FSEL_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       csr_addr,
    input  logic                    csr_wr,
    input  logic [31:0]             csr_wdata,
    input  logic                    csr_rd,
    output logic [31:0]             csr_rdata,
    output logic                    csr_rvalid,
    input  logic [LANES-1:0]        word_lock_i,
    input  logic [LANES-1:0]        cdr_lock_i,
    input  logic [NTYPES*LANES-1:0] fifo_flags_i,
    input  logic                    frame_err_i,
    input  logic                    pcs_aligned_i,
    input  logic                    deskew_done_i,
    input  logic                    deskew_err_i,
    output logic [LANES-1:0]        loopback_o
);
    reg_sel_e          sel;
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [31:0]       scratch_q;
    logic [LANES-1:0]  loop_q;
    logic [FSEL_W-1:0] fsel_q;
    logic              clr_q;
    logic              frm_err_q;
    logic              dsk_err_q;
    logic              lock_lost;
    logic [LANES-1:0]  flag_lanes;
    logic [31:0]       rd_word;

    phy_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    phy_csr_flag_mux #(.LANES(LANES), .FSEL_W(FSEL_W)) u_fmux (
        .flags_i (fifo_flags_i),
        .sel_i   (fsel_q),
        .lanes_o (flag_lanes)
    );

    assign lock_lost = ~(&word_lock_i);

    phy_csr_sticky u_frm (
        .clk        (clk),
        .rst        (rst),
        .set_i      (frame_err_i),
        .hold_clr_i (clr_q | lock_lost),
        .q          (frm_err_q)
    );

    phy_csr_sticky u_dsk (
        .clk        (clk),
        .rst        (rst),
        .set_i      (deskew_err_i),
        .hold_clr_i (clr_q),
        .q          (dsk_err_q)
    );

    // Writable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            loop_q    <= '0;
            fsel_q    <= '0;
            clr_q     <= 1'b0;
        end else if (csr_wr) begin
            case (sel)
                SEL_SCRATCH: scratch_q <= csr_wdata;
                SEL_LOOP:    loop_q    <= csr_wdata[LANES-1:0];
                SEL_FSEL:    fsel_q    <= csr_wdata[FSEL_W-1:0];
                SEL_CLR:     clr_q     <= csr_wdata[0];
                default:     ;
            endcase
        end
    end

    assign loopback_o = loop_q;

    // Read word selection
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_REV:     rd_word = REV_ID;
            SEL_SCRATCH: rd_word = scratch_q;
            SEL_NAME0:   rd_word = NAME0_VAL;
            SEL_NAME1:   rd_word = NAME1_VAL;
            SEL_NAME2:   rd_word = NAME2_VAL;
            SEL_WLOCK:   rd_word[LANES-1:0]  = word_lock_i;
            SEL_LOOP:    rd_word[LANES-1:0]  = loop_q;
            SEL_FSEL:    rd_word[FSEL_W-1:0] = fsel_q;
            SEL_FDATA:   rd_word[LANES-1:0]  = flag_lanes;
            SEL_CDR:     rd_word[LANES-1:0]  = cdr_lock_i;
            SEL_FRMERR:  rd_word[0]          = frm_err_q;
            SEL_CLR:     rd_word[0]          = clr_q;
            SEL_ALIGNED: rd_word[0]          = pcs_aligned_i;
            SEL_DESKEW:  rd_word[1:0]        = {dsk_err_q, deskew_done_i};
            SEL_NONE:    rd_word = '0;
        endcase
    end

    // Read response state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = csr_rd ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = csr_rd ? RD_RESP : RD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data capture
    always_ff @(posedge clk) begin
        if (rst) begin
            csr_rdata <= '0;
        end else if (csr_rd) begin
            csr_rdata <= rd_word;
        end
    end

    // Outputs of the state machine
    always_comb begin
        csr_rvalid = 1'b0;
        unique case (state_q)
            RD_IDLE: csr_rvalid = 1'b0;
            RD_RESP: csr_rvalid = 1'b1;
        endcase
    end
endmodule

// File: rtl/phy_csr_checker.sv
module phy_csr_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             csr_rd,
    input logic             csr_wr,
    input logic             csr_rvalid,
    input logic [LANES-1:0] loopback_o,
    input logic [LANES-1:0] word_lock_i,
    input logic             clr_q,
    input logic             frm_err_q,
    input logic             dsk_err_q
);
    a_r11_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        csr_rd |=> csr_rvalid);

    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !csr_rd |=> !csr_rvalid);

    a_r8_clear_holds_frame: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !frm_err_q);

    a_r8_clear_holds_deskew: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> !dsk_err_q);

    a_r9_lockloss_clears: assert property (@(posedge clk) disable iff (rst)
        !(&word_lock_i) |=> !frm_err_q);

    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (frm_err_q && !clr_q && (&word_lock_i)) |=> frm_err_q);

    a_r4_loop_stable: assert property (@(posedge clk) disable iff (rst)
        !csr_wr |=> $stable(loopback_o));
endmodule

bind phy_csr_bank phy_csr_checker #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_rd      (csr_rd),
    .csr_wr      (csr_wr),
    .csr_rvalid  (csr_rvalid),
    .loopback_o  (loopback_o),
    .word_lock_i (word_lock_i),
    .clr_q       (clr_q),
    .frm_err_q   (frm_err_q),
    .dsk_err_q   (dsk_err_q)
);

// File: tb/phy_csr_bank_tb.sv
module phy_csr_bank_tb;
    localparam int          LANES  = 4;
    localparam int          ADDR_W = 12;
    localparam logic [31:0] REV    = 32'h0001_0200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] csr_addr = '0;
    logic              csr_wr = 1'b0;
    logic [31:0]       csr_wdata = '0;
    logic              csr_rd = 1'b0;
    logic [31:0]       csr_rdata;
    logic              csr_rvalid;
    logic [LANES-1:0]  word_lock_i = '1;
    logic [LANES-1:0]  cdr_lock_i = '0;
    logic [8*LANES-1:0] fifo_flags_i = '0;
    logic              frame_err_i = 1'b0;
    logic              pcs_aligned_i = 1'b0;
    logic              deskew_done_i = 1'b0;
    logic              deskew_err_i = 1'b0;
    logic [LANES-1:0]  loopback_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    phy_csr_bank #(.LANES(LANES), .ADDR_W(ADDR_W), .REV_ID(REV)) u_dut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
        .csr_rvalid(csr_rvalid), .word_lock_i(word_lock_i),
        .cdr_lock_i(cdr_lock_i), .fifo_flags_i(fifo_flags_i),
        .frame_err_i(frame_err_i), .pcs_aligned_i(pcs_aligned_i),
        .deskew_done_i(deskew_done_i), .deskew_err_i(deskew_err_i),
        .loopback_o(loopback_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog got=%0d exp=<50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = ADDR_W'(a); csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        @(negedge clk);
        csr_addr = ADDR_W'(a); csr_rd = 1'b1;
        @(negedge clk);
        csr_rd = 1'b0;
        chk({tag, " rvalid"}, 32'(csr_rvalid), 32'd1);
        chk(tag, csr_rdata, exp);
        @(negedge clk);
        chk({tag, " rvalid pulse"}, 32'(csr_rvalid), 32'd0);
    endtask

    task automatic pulse_ferr();
        @(negedge clk); frame_err_i = 1'b1;
        @(negedge clk); frame_err_i = 1'b0;
    endtask

    task automatic pulse_derr();
        @(negedge clk); deskew_err_i = 1'b1;
        @(negedge clk); deskew_err_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rvalid", 32'(csr_rvalid), 32'd0);
        chk("R1 loopback_o", 32'(loopback_o), 32'd0);
        rd_chk("R1 scratch", 32'h301, 32'h0);
        rd_chk("R1 loop", 32'h313, 32'h0);
        rd_chk("R1 fsel", 32'h314, 32'h0);
        rd_chk("R1 clr", 32'h324, 32'h0);
        rd_chk("R1 frmerr", 32'h323, 32'h0);

        // R2 identification, write ignored
        rd_chk("R2 rev", 32'h300, REV);
        wr(32'h302, 32'hFFFF_FFFF);
        wr(32'h300, 32'h1234_5678);
        rd_chk("R2 rev after wr", 32'h300, REV);
        rd_chk("R2 name0", 32'h302, 32'h0000_3235);
        rd_chk("R2 name1", 32'h303, 32'h0000_4745);
        rd_chk("R2 name2", 32'h304, 32'h0070_6373);

        // R3 scratch patterns
        for (int i = 0; i < 32; i++) begin
            logic [31:0] p;
            p = (32'h1 << i) ^ (32'hA5A5_0000 + 32'(i * 7919));
            wr(32'h301, p);
            rd_chk("R3 scratch", 32'h301, p);
        end

        // R4 loopback sweep
        for (int v = 0; v < 16; v++) begin
            wr(32'h313, 32'hFFFF_FFF0 | 32'(v));
            chk("R4 loopback_o", 32'(loopback_o), 32'(v));
            rd_chk("R4 loop readback", 32'h313, 32'(v));
        end

        // R5 live status sweep
        for (int v = 0; v < 16; v++) begin
            word_lock_i = 4'(v);
            cdr_lock_i  = 4'(15 - v);
            pcs_aligned_i = v[0];
            rd_chk("R5 wlock", 32'h312, 32'(v));
            rd_chk("R5 cdr", 32'h321, 32'(15 - v));
            rd_chk("R5 aligned", 32'h326, 32'(v % 2));
        end
        word_lock_i = '1;

        // R6 indirect flag window over all codes
        fifo_flags_i = 32'h9C3E_5A71;
        for (int s = 0; s < 8; s++) begin
            wr(32'h314, 32'hFFFF_FFF8 | 32'(s));
            rd_chk("R6 fsel", 32'h314, 32'(s));
            rd_chk("R6 fdata", 32'h315, (fifo_flags_i >> (s * LANES)) & 32'hF);
        end

        // R11 unmapped addresses
        wr(32'h301, 32'h5555_AAAA);
        for (int a = 32'h305; a < 32'h312; a++) begin
            wr(a, 32'hFFFF_FFFF);
            rd_chk("R11 unmapped", a, 32'h0);
        end
        rd_chk("R11 unmapped 0x3ff", 32'h3FF, 32'h0);
        rd_chk("R11 scratch kept", 32'h301, 32'h5555_AAAA);

        // R7 sticky frame error, R10 deskew
        deskew_done_i = 1'b1;
        rd_chk("R7 before", 32'h323, 32'h0);
        pulse_ferr();
        rd_chk("R7 set", 32'h323, 32'h1);
        rd_chk("R7 stays", 32'h323, 32'h1);
        rd_chk("R10 deskew live", 32'h329, 32'h1);
        pulse_derr();
        rd_chk("R10 deskew sticky", 32'h329, 32'h3);
        deskew_done_i = 1'b0;
        rd_chk("R10 deskew held", 32'h329, 32'h2);

        // R8 level-held clear
        wr(32'h324, 32'h1);
        rd_chk("R8 clr reads 1", 32'h324, 32'h1);
        rd_chk("R8 frmerr cleared", 32'h323, 32'h0);
        rd_chk("R8 deskew cleared", 32'h329, 32'h0);
        pulse_ferr();
        pulse_derr();
        rd_chk("R8 frmerr blocked", 32'h323, 32'h0);
        rd_chk("R8 deskew blocked", 32'h329, 32'h0);
        wr(32'h324, 32'h0);
        rd_chk("R8 clr reads 0", 32'h324, 32'h0);
        pulse_ferr();
        pulse_derr();
        rd_chk("R8 frmerr resumes", 32'h323, 32'h1);
        rd_chk("R8 deskew resumes", 32'h329, 32'h2);

        // R9 loss of word lock on one lane
        @(negedge clk); word_lock_i = 4'b1011;
        @(negedge clk);
        rd_chk("R9 cleared on lock loss", 32'h323, 32'h0);
        pulse_ferr();
        rd_chk("R9 blocked while unlocked", 32'h323, 32'h0);
        rd_chk("R10 deskew unaffected by lock", 32'h329, 32'h2);
        word_lock_i = '1;
        pulse_ferr();
        rd_chk("R9 records after relock", 32'h323, 32'h1);

        // R11 back-to-back reads
        @(negedge clk); csr_addr = ADDR_W'(32'h302); csr_rd = 1'b1;
        @(negedge clk); csr_addr = ADDR_W'(32'h303);
        chk("R11 b2b first valid", 32'(csr_rvalid), 32'd1);
        chk("R11 b2b first data", csr_rdata, 32'h0000_3235);
        @(negedge clk); csr_rd = 1'b0;
        chk("R11 b2b second valid", 32'(csr_rvalid), 32'd1);
        chk("R11 b2b second data", csr_rdata, 32'h0000_4745);
        @(negedge clk);
        chk("R11 b2b end", 32'(csr_rvalid), 32'd0);

        // R1 reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 loop after reset", 32'(loopback_o), 32'd0);
        rd_chk("R1 frmerr after reset", 32'h323, 32'h0);
        rd_chk("R1 deskew after reset", 32'h329, 32'h0);
        rd_chk("R1 scratch after reset", 32'h301, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule